// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the register-side controller of an on-chip flash array. Software stages a word address, a data word and a command code through a small register port, then asks for a launch. The block checks the request and places it in a one-deep pending slot. When the execution slot is idle, the command moves there and starts the array through a start/done handshake. A status register reports whether the pending slot is free and whether all work has finished. It also holds two sticky error flags: one for protection violations and one for access or sequence errors.

The register port uses one select for both reads and writes: 0 is status, 1 is command, 2 is address and 3 is data. Read data is combinational from `reg_sel`. The status bits are bit 3 buffer-empty, bit 2 complete, bit 1 protection-violation and bit 0 access-error. A write to status with bit 3 set is a launch request. A write with bit 1 or bit 0 set clears that flag. A launch request is judged on the flag values that stand before the same write.

Top module: `flash_cmd_seq`

## Requirements
- R1: Command codes 0x05, 0x20, 0x40 and 0x41 are accepted. A launch with one of them produces a single-cycle `flash_start` carrying that code, the staged address and the staged data.
- R2: A write of any other code to the command register sets access-error (status bit 0). The command register keeps its previous value, and nothing is started.
- R3: A launch whose address lies in [PROT_LO, PROT_HI] sets protection-violation (status bit 1) and starts nothing.
- R4: The protection-violation and access-error flags stay set until a 1 is written to their own status bit. Writing 0 there leaves them set.
- R5: The complete flag (status bit 2) ignores writes. It clears in the same cycle an accepted launch clears buffer-empty. It sets one cycle after both slots are idle. It is 1 out of reset.
- R6: `stop_req` while a command is executing sets access-error. `stop_req` while idle does not.
- R7: A launch with address bit 0 equal to 1 sets access-error and starts nothing.
- R8: Address bit 15 always reads and launches as 0.
- R9: With `special_mode` low, the address and data registers read 0 and ignore writes.
- R10: Buffer-empty (status bit 3) is 1 exactly when the pending slot is free. A launch while the slot is full sets access-error and is dropped.
- R11: A launch is refused, with access-error set, while either error flag is set.
- R12: A program (0x20) completes when `flash_done` is seen. The erase types (0x05, 0x40, 0x41) complete ERASE_TAIL cycles after it. The complete flag is therefore visible 1 cycle after the done edge for a program and ERASE_TAIL+1 cycles after it for an erase.
- R13: Commands start in launch order. A queued command starts only after the executing one has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | Enables access to the address and data registers |
| stop_req | input | 1 | Stop request from the processor |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data of the selected register |
| flash_start | output | 1 | One-cycle start pulse to the array |
| flash_cmd | output | 8 | Command code for the array |
| flash_addr | output | W | Word address for the array |
| flash_wdata | output | W | Data word for the array |
| flash_done | input | 1 | One-cycle completion pulse from the array |

## Verification
The assertions check the following on every cycle:
- both error flags stay sticky unless their clear bit is written;
- complete is never high while a slot is busy, and it drops whenever the pending slot fills;
- each start is a single pulse that drains a filled pending slot;
- the address MSB reads as zero, and the address and data registers read zero outside special mode;
- a stop request during execution raises access-error.

Only the bench scenarios show the rest. These are the exact completion latency per command type, the launch ordering across the pending and active slots, and the refusal and decoding rules. That includes the rule that a rejected command leaves the command register unchanged and starts nothing.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int W          = 16,
  parameter int PROT_LO    = 'h7000,
  parameter int PROT_HI    = 'h7FFF,
  parameter int ERASE_TAIL = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         special_mode,
  input  logic         stop_req,
  input  logic         reg_wr,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         flash_start,
  output logic [7:0]   flash_cmd,
  output logic [W-1:0] flash_addr,
  output logic [W-1:0] flash_wdata,
  input  logic         flash_done
);
  localparam logic [1:0] SEL_STAT = 2'd0, SEL_CMD = 2'd1, SEL_ADDR = 2'd2, SEL_DATA = 2'd3;
  localparam int CW = $clog2(ERASE_TAIL + 2);

  function automatic logic known_cmd(input logic [7:0] c);
    return c == 8'h05 || c == 8'h20 || c == 8'h40 || c == 8'h41;
  endfunction

  logic [7:0]   cmd_q, pend_cmd;
  logic [W-1:0] addr_q, data_q, pend_addr, pend_data;
  logic         pend_v, act_busy, act_tail, act_erase;
  logic [CW-1:0] tail_cnt;
  logic         pviol_q, accerr_q, cmpl_q;

  wire wr_stat    = reg_wr && reg_sel == SEL_STAT;
  wire wr_cmd     = reg_wr && reg_sel == SEL_CMD;
  wire launch_req = wr_stat && reg_wdata[3];
  wire in_prot    = addr_q >= W'(PROT_LO) && addr_q <= W'(PROT_HI);
  wire seq_err    = launch_req && (pend_v || pviol_q || accerr_q || !known_cmd(cmd_q) || addr_q[0]);
  wire prot_err   = launch_req && !seq_err && in_prot;
  wire accept     = launch_req && !seq_err && !in_prot;
  wire move       = pend_v && !act_busy;
  wire cmd_bad    = wr_cmd && !known_cmd(reg_wdata[7:0]);
  wire stop_err   = stop_req && act_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_cmd && !cmd_bad) cmd_q <= reg_wdata[7:0];
      if (reg_wr && reg_sel == SEL_ADDR && special_mode) addr_q <= {1'b0, reg_wdata[W-2:0]};
      if (reg_wr && reg_sel == SEL_DATA && special_mode) data_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_cmd  <= '0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (accept) begin
      pend_v    <= 1'b1;
      pend_cmd  <= cmd_q;
      pend_addr <= addr_q;
      pend_data <= data_q;
    end else if (move) begin
      pend_v    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_busy    <= 1'b0;
      act_tail    <= 1'b0;
      act_erase   <= 1'b0;
      tail_cnt    <= '0;
      flash_start <= 1'b0;
      flash_cmd   <= '0;
      flash_addr  <= '0;
      flash_wdata <= '0;
    end else begin
      flash_start <= move;
      if (move) begin
        act_busy    <= 1'b1;
        act_tail    <= 1'b0;
        act_erase   <= pend_cmd != 8'h20;
        flash_cmd   <= pend_cmd;
        flash_addr  <= pend_addr;
        flash_wdata <= pend_data;
      end else if (act_tail) begin
        tail_cnt <= tail_cnt - 1'b1;
        if (tail_cnt == CW'(1)) begin
          act_tail <= 1'b0;
          act_busy <= 1'b0;
        end
      end else if (act_busy && flash_done) begin
        if (act_erase && ERASE_TAIL != 0) begin
          act_tail <= 1'b1;
          tail_cnt <= CW'(ERASE_TAIL);
        end else begin
          act_busy <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pviol_q  <= 1'b0;
      accerr_q <= 1'b0;
      cmpl_q   <= 1'b1;
    end else begin
      if (prot_err) pviol_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) pviol_q <= 1'b0;
      if (seq_err || cmd_bad || stop_err) accerr_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) accerr_q <= 1'b0;
      if (accept) cmpl_q <= 1'b0;
      else if (!pend_v && !act_busy) cmpl_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_STAT: reg_rdata = {{(W-4){1'b0}}, ~pend_v, cmpl_q, pviol_q, accerr_q};
      SEL_CMD:  reg_rdata = {{(W-8){1'b0}}, cmd_q};
      SEL_ADDR: reg_rdata = special_mode ? addr_q : '0;
      default:  reg_rdata = special_mode ? data_q : '0;
    endcase
  end
endmodule

module flash_cmd_seq_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         special_mode,
  input logic         stop_req,
  input logic         reg_wr,
  input logic [1:0]   reg_sel,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] reg_rdata,
  input logic         flash_start,
  input logic         act_busy,
  input logic         pend_v,
  input logic         pviol_q,
  input logic         accerr_q,
  input logic         cmpl_q
);
  wire clr_pv = reg_wr && reg_sel == 2'd0 && reg_wdata[1];
  wire clr_ae = reg_wr && reg_sel == 2'd0 && reg_wdata[0];

  assert_pviol_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pviol_q && !clr_pv |=> pviol_q);
  assert_accerr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accerr_q && !clr_ae |=> accerr_q);
  assert_cmpl_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_q |-> !act_busy && !pend_v);
  assert_cmpl_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_v) |-> !cmpl_q);
  assert_stop_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && act_busy |=> accerr_q);
  assert_addr_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == 2'd2 |-> !reg_rdata[W-1]);
  assert_normal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !special_mode && reg_sel[1] |-> reg_rdata == '0);
  assert_start_drains_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_start) |-> $past(pend_v) && !pend_v);
  assert_start_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    flash_start |=> !flash_start);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .stop_req(stop_req),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .flash_start(flash_start), .act_busy(act_busy), .pend_v(pend_v),
  .pviol_q(pviol_q), .accerr_q(accerr_q), .cmpl_q(cmpl_q)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
  localparam int TAIL = 4;
  localparam int LAT  = 20;

  logic clk = 0, rst_n = 0, special_mode = 1, stop_req = 0, reg_wr = 0, flash_done = 0;
  logic [1:0]  reg_sel = 0;
  logic [15:0] reg_wdata = 0, reg_rdata, flash_addr, flash_wdata;
  logic [7:0]  flash_cmd;
  logic        flash_start;

  flash_cmd_seq #(.W(16), .PROT_LO('h7000), .PROT_HI('h7FFF), .ERASE_TAIL(TAIL)) u_dut (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .stop_req(stop_req),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flash_start(flash_start), .flash_cmd(flash_cmd), .flash_addr(flash_addr),
    .flash_wdata(flash_wdata), .flash_done(flash_done));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, done_cyc = 0, starts = 0;
  logic [39:0] exp_q[$];

  always @(posedge clk) cyc++;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && flash_start) begin
      starts++;
      if (exp_q.size() == 0) chk(0, "R13 unexpected start", flash_cmd, 0);
      else begin
        logic [39:0] e, a;
        e = exp_q.pop_front();
        a = {flash_cmd, flash_addr, flash_wdata};
        chk(a == e, "R1/R13 start contents", a, e);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (flash_start) begin
        repeat (LAT) @(negedge clk);
        flash_done = 1;
        done_cyc = cyc;
        @(negedge clk);
        flash_done = 0;
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic launch(input logic [7:0] c, input logic [15:0] a, input logic [15:0] d, input logic ok);
    wr(2, a); wr(3, d); wr(1, {8'h00, c});
    if (ok) exp_q.push_back({c, a & 16'h7FFF, d});
    wr(0, 16'h0008);
  endtask

  task automatic wait_cmpl(input int exp_lat, input string tag);
    logic [15:0] v;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      rd(0, v);
      if (v[2]) begin
        chk(cyc - done_cyc == exp_lat, tag, cyc - done_cyc, exp_lat);
        return;
      end
    end
    chk(0, {tag, " timeout"}, 0, 1);
  endtask

  task automatic stat(input logic [3:0] exp, input string tag);
    logic [15:0] v;
    @(negedge clk);
    rd(0, v);
    chk(v[3:0] == exp, tag, v[3:0], exp);
  endtask

  initial begin
    logic [15:0] v;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    stat(4'b1100, "R5/R10 reset status");

    launch(8'h20, 16'h1000, 16'hBEEF, 1);
    wait_cmpl(2, "R12 program latency");
    launch(8'h40, 16'h2000, 16'h0001, 1);
    wait_cmpl(TAIL + 2, "R12 sector erase latency");
    launch(8'h05, 16'h0000, 16'h0002, 1);
    wait_cmpl(TAIL + 2, "R12 erase-verify latency");
    launch(8'h41, 16'h0100, 16'h0003, 1);
    wait_cmpl(TAIL + 2, "R1 bulk erase latency");
    chk(starts == 4, "R1 four starts", starts, 4);

    wr(1, 16'h0033);
    stat(4'b1101, "R2 bad code sets access error");
    @(negedge clk); rd(1, v);
    chk(v == 16'h0041, "R2 command register kept", v, 16'h0041);
    s0 = starts;
    wr(0, 16'h0008);
    repeat (4) @(negedge clk);
    chk(starts == s0, "R11 launch refused while error set", starts, s0);
    wr(0, 16'h0000);
    stat(4'b1101, "R4 write 0 keeps access error");
    wr(0, 16'h0001);
    stat(4'b1100, "R4 write 1 clears access error");

    launch(8'h20, 16'h7100, 16'h5555, 0);
    stat(4'b1110, "R3 protected address");
    repeat (4) @(negedge clk);
    chk(starts == s0, "R3 no start", starts, s0);
    wr(0, 16'h0002);
    stat(4'b1100, "R4 clear protection flag");

    launch(8'h20, 16'h1001, 16'h5555, 0);
    stat(4'b1101, "R7 misaligned address");
    wr(0, 16'h0001);

    wr(2, 16'hFFFF);
    @(negedge clk); rd(2, v);
    chk(v == 16'h7FFF, "R8 address bit 15 zero", v, 16'h7FFF);
    wr(3, 16'hA5A5);
    special_mode = 0;
    @(negedge clk); rd(2, v);
    chk(v == 0, "R9 address reads zero", v, 0);
    rd(3, v);
    chk(v == 0, "R9 data reads zero", v, 0);
    wr(2, 16'h1234);
    special_mode = 1;
    @(negedge clk); rd(2, v);
    chk(v == 16'h7FFF, "R9 normal write ignored", v, 16'h7FFF);

    launch(8'h20, 16'h1000, 16'h1111, 1);
    launch(8'h40, 16'h2000, 16'h2222, 1);
    stat(4'b0000, "R10 pending slot full");
    wr(0, 16'h0008);
    stat(4'b0001, "R10 launch while full");
    wr(0, 16'h0004);
    stat(4'b0001, "R5 complete ignores write");
    wr(0, 16'h0001);
    s0 = starts;
    while (starts == s0 + 0 && exp_q.size() == 2) @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    stat(4'b1000, "R13 second running, not complete");
    wait_cmpl(TAIL + 2, "R5 complete after queue drains");

    stop_req = 1; @(negedge clk); stop_req = 0;
    stat(4'b1100, "R6 stop while idle");
    launch(8'h20, 16'h3000, 16'h0F0F, 1);
    while (exp_q.size() != 0) @(negedge clk);
    stop_req = 1; @(negedge clk); stop_req = 0;
    stat(4'b1001, "R6 stop while executing");
    wait_cmpl(2, "R6 command still completes");
    wr(0, 16'h0001);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R13 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule